// File: doc/BRIEF.md
# Telephone Line Event Interrupt Controller

This block gathers line-event indications from a telephone line interface and condenses them into a single interrupt pin and a ring-indicator pin. Its inputs are already-qualified digital detector outputs: a validated ring envelope, a raw ring-threshold crossing, a receive-overload level, a billing-tone disturbance and a loop-current dropout. Each input passes a two-flop synchronizer. The block then keeps sticky status and interrupt flags, one live overload mirror, per-source masks and a global enable.

Software writes control, mask and status registers through a one-cycle address/data/strobe port. It reads any register through a combinational read port. Each source has its own clearing rule. Ring, overload and dropout flags are cleared by writing zero. The live overload bit clears itself. The billing-tone pair is cleared only by turning its enable off. The ring pin follows either the validated envelope or a one-shot of fixed length started by a threshold crossing.

Register map (2-bit address): 0 = CTRL, 1 = MASK, 2 = STAT, 3 = LIVE (read only).

Top module: `line_evt_intc`

## Requirements
- R1: With CTRL bit 2 at 0 (reset value), STAT bit 0 (ring flag) sets only on a rising edge of the synchronized ring envelope. A falling edge leaves it unchanged.
- R2: With CTRL bit 2 at 1, STAT bit 0 sets on both rising and falling edges of the synchronized ring envelope.
- R3: A write to STAT clears every writable bit (0, 1, 2, 5, 6) whose data bit is 0 and leaves bits written as 1 alone. A set event in the same cycle takes priority over the clear.
- R4: While the synchronized overload input is high, STAT bit 1 (overload status) and bit 2 (overload interrupt) are set. Both stay set after the input falls until software clears them.
- R5: LIVE bit 1 follows the synchronized overload input and returns to 0 by itself once the input is low, whatever the sticky bits hold.
- R6: The interrupt condition is CTRL bit 0 (global enable) AND the OR of STAT bit 0, 2, 4 and 6, each ANDed with MASK bit 0, 1, 2 and 3 in that order. With CTRL bit 1 at 1 the pin is high when the condition holds. With CTRL bit 1 at 0 it is low when the condition holds.
- R7: STAT bits 3 and 4 (billing-tone detect and interrupt) set from the billing-tone input only while CTRL bit 4 is 1. Writing CTRL bit 4 to 0 clears both. STAT writes do not affect them.
- R8: A loop-current dropout sets STAT bits 5 and 6, which stay set until cleared by a STAT write.
- R9: With CTRL bit 3 at 0 the ring pin follows the synchronized ring envelope. With CTRL bit 3 at 1 it is high for exactly ONESHOT_CYC cycles after a rising edge of the synchronized threshold crossing. A crossing while the pulse is active does not extend it.
- R10: After reset, CTRL, MASK and STAT read 0, the interrupt pin is high (inactive, low-active polarity) and the ring pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_env_i | input | 1 | Validated ring envelope |
| ring_cross_i | input | 1 | Unqualified ring-threshold crossing |
| rx_ovl_i | input | 1 | Receive overload level |
| btone_i | input | 1 | Billing-tone disturbance level |
| loop_drop_i | input | 1 | Loop-current dropout level |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| ring_pin_o | output | 1 | Ring indicator pin |
| irq_pin_o | output | 1 | Interrupt pin with programmable polarity |

## Verification
A software clear of STAT and a detector set event can land in the same cycle. The bench provokes this by holding the overload input high until it has passed the synchronizer, then writing zeros to STAT. It expects the overload bits to read back as set. A second coincidence is a threshold crossing that arrives while the ring one-shot is running. The bench injects it partway through the pulse and counts the pin's high cycles, which must still equal the configured length.

// File: rtl/lei_pkg.sv
package lei_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_LIVE = 2'd3;

    localparam int unsigned N_SRC = 5;

    typedef struct packed {
        logic bt_en;
        logic ring_pin_sel;
        logic ring_both;
        logic irq_pol;
        logic gie;
    } ctrl_t;

    typedef struct packed {
        logic drop;
        logic bt;
        logic ovl;
        logic ring;
    } mask_t;

    typedef struct packed {
        logic drop_int;
        logic drop_stat;
        logic bt_int;
        logic bt_det;
        logic ovl_int;
        logic ovl_stat;
        logic ring_flag;
    } stat_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned MASK_W = $bits(mask_t);
    localparam int unsigned STAT_W = $bits(stat_t);

    localparam stat_t STAT_SW_CLEARABLE = '{
        drop_int: 1'b1, drop_stat: 1'b1, bt_int: 1'b0, bt_det: 1'b0,
        ovl_int: 1'b1, ovl_stat: 1'b1, ring_flag: 1'b1
    };

    typedef struct packed {
        ctrl_t ctrl;
        mask_t mask;
        stat_t stat;
        logic  env_prev;
    } regs_t;

endpackage

// File: rtl/lei_sync.sv
module lei_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lei_oneshot.sv
module lei_oneshot #(
    parameter int unsigned PULSE_CYC = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             trig_prev_d, trig_prev_q;

    always_comb begin
        cnt_d       = cnt_q;
        trig_prev_d = trig_i;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (trig_i && !trig_prev_q) begin
            cnt_d = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            trig_prev_q <= 1'b0;
        end else begin
            cnt_q       <= cnt_d;
            trig_prev_q <= trig_prev_d;
        end
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/line_evt_intc.sv
module line_evt_intc
    import lei_pkg::*;
#(
    parameter int unsigned ONESHOT_CYC = 500_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_env_i,
    input  logic              ring_cross_i,
    input  logic              rx_ovl_i,
    input  logic              btone_i,
    input  logic              loop_drop_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ring_pin_o,
    output logic              irq_pin_o
);

    logic [N_SRC-1:0] raw_in, sync_in;
    logic env_s, cross_s, ovl_s, bt_s, drop_s;
    logic os_active;
    logic irq_act;
    regs_t regs_d, regs_q;

    assign raw_in = {ring_env_i, ring_cross_i, rx_ovl_i, btone_i, loop_drop_i};
    assign {env_s, cross_s, ovl_s, bt_s, drop_s} = sync_in;

    lei_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    lei_oneshot #(.PULSE_CYC(ONESHOT_CYC)) u_oneshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (cross_s),
        .active_o (os_active)
    );

    // next-state computation
    always_comb begin
        logic  wr_ctrl, wr_mask, wr_stat;
        logic  ring_evt;
        stat_t clr;
        stat_t cur;

        regs_d  = regs_q;
        cur     = regs_q.stat;
        wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_mask = wr_en_i && (wr_addr_i == ADDR_MASK);
        wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);

        if (wr_ctrl) regs_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
        if (wr_mask) regs_d.mask = mask_t'(wr_data_i[MASK_W-1:0]);

        clr = wr_stat ? stat_t'(~wr_data_i[STAT_W-1:0] & STAT_SW_CLEARABLE) : stat_t'('0);

        ring_evt = (env_s && !regs_q.env_prev)
                 || (regs_q.ctrl.ring_both && !env_s && regs_q.env_prev);
        regs_d.env_prev = env_s;

        // set has priority over a same-cycle software clear
        regs_d.stat.ring_flag = (cur.ring_flag & ~clr.ring_flag) | ring_evt;
        regs_d.stat.ovl_stat  = (cur.ovl_stat  & ~clr.ovl_stat)  | ovl_s;
        regs_d.stat.ovl_int   = (cur.ovl_int   & ~clr.ovl_int)   | ovl_s;
        regs_d.stat.drop_stat = (cur.drop_stat & ~clr.drop_stat) | drop_s;
        regs_d.stat.drop_int  = (cur.drop_int  & ~clr.drop_int)  | drop_s;

        if (!regs_d.ctrl.bt_en) begin
            regs_d.stat.bt_det = 1'b0;
            regs_d.stat.bt_int = 1'b0;
        end else begin
            regs_d.stat.bt_det = cur.bt_det | (bt_s & regs_q.ctrl.bt_en);
            regs_d.stat.bt_int = cur.bt_int | (bt_s & regs_q.ctrl.bt_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // outputs
    always_comb begin
        logic [MASK_W-1:0] pend;
        pend = {regs_q.stat.drop_int, regs_q.stat.bt_int,
                regs_q.stat.ovl_int, regs_q.stat.ring_flag};
        irq_act    = regs_q.ctrl.gie && |(pend & regs_q.mask);
        irq_pin_o  = regs_q.ctrl.irq_pol ? irq_act : !irq_act;
        ring_pin_o = regs_q.ctrl.ring_pin_sel ? os_active : env_s;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_CTRL: rd_data_o[CTRL_W-1:0] = regs_q.ctrl;
            ADDR_MASK: rd_data_o[MASK_W-1:0] = regs_q.mask;
            ADDR_STAT: rd_data_o[STAT_W-1:0] = regs_q.stat;
            default:   rd_data_o[3:0] = {irq_act, ring_pin_o, ovl_s, env_s};
        endcase
    end

endmodule

// File: rtl/lei_intc_chk.sv
module lei_intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] stat,
    input logic [4:0] ctrl,
    input logic       env_s,
    input logic       ovl_s,
    input logic       irq_pin,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data
);

    AST_RING_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat[0]) && !$past(ctrl[2])) |-> ($past(env_s) && !$past(env_s, 2))); // R1

    AST_RING_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[0]) |-> $past(wr_en && (wr_addr == 2'd2) && !wr_data[0])); // R3

    AST_OVL_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> $past(ovl_s)); // R4

    AST_BT_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[4] |-> (stat[4:3] == 2'b00)); // R7

    AST_IRQ_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> (irq_pin == !ctrl[1])); // R6

    AST_DROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[6]) |-> $past(wr_en && (wr_addr == 2'd2) && !wr_data[6])); // R8

endmodule

bind line_evt_intc lei_intc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat    (regs_q.stat),
    .ctrl    (regs_q.ctrl),
    .env_s   (env_s),
    .ovl_s   (ovl_s),
    .irq_pin (irq_pin_o),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i)
);

// File: tb/line_evt_intc_test.sv
`timescale 1ns/1ps
module line_evt_intc_test;

    localparam int unsigned PULSE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_env = 0, ring_cross = 0, rx_ovl = 0, btone = 0, loop_drop = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic ring_pin, irq_pin;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_evt_intc #(.ONESHOT_CYC(PULSE)) uut (
        .clk(clk), .rst_n(rst_n),
        .ring_env_i(ring_env), .ring_cross_i(ring_cross), .rx_ovl_i(rx_ovl),
        .btone_i(btone), .loop_drop_i(loop_drop),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ring_pin_o(ring_pin), .irq_pin_o(irq_pin)
    );

    // vector: wr(1) addr(2) data(8) inputs{env,cross,ovl,bt,drop}(5) exp_stat(8) pad(7) exp_irq(1)
    localparam int NV = 26;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,2'd0,8'h11,5'b00000,8'h00,7'd0,1'b1}, // 0 gie + bt_en
        {1'b1,2'd1,8'h0F,5'b00000,8'h00,7'd0,1'b1}, // 1 all masks
        {1'b0,2'd0,8'h00,5'b10000,8'h01,7'd0,1'b0}, // 2 R1 rise
        {1'b1,2'd2,8'h00,5'b10000,8'h00,7'd0,1'b1}, // 3 R3 clear
        {1'b0,2'd0,8'h00,5'b00000,8'h00,7'd0,1'b1}, // 4 R1 fall ignored
        {1'b1,2'd0,8'h15,5'b00000,8'h00,7'd0,1'b1}, // 5 both edges
        {1'b0,2'd0,8'h00,5'b10000,8'h01,7'd0,1'b0}, // 6 R2 rise
        {1'b1,2'd2,8'h00,5'b10000,8'h00,7'd0,1'b1}, // 7
        {1'b0,2'd0,8'h00,5'b00000,8'h01,7'd0,1'b0}, // 8 R2 fall
        {1'b1,2'd2,8'h00,5'b00000,8'h00,7'd0,1'b1}, // 9
        {1'b0,2'd0,8'h00,5'b00100,8'h06,7'd0,1'b0}, // 10 R4 overload
        {1'b1,2'd2,8'h00,5'b00100,8'h06,7'd0,1'b0}, // 11 R3 set wins
        {1'b0,2'd0,8'h00,5'b00000,8'h06,7'd0,1'b0}, // 12 R4 sticky
        {1'b1,2'd2,8'h00,5'b00000,8'h00,7'd0,1'b1}, // 13
        {1'b1,2'd1,8'h0D,5'b00000,8'h00,7'd0,1'b1}, // 14 ovl mask off
        {1'b0,2'd0,8'h00,5'b00100,8'h06,7'd0,1'b1}, // 15 R6 masked
        {1'b1,2'd2,8'h00,5'b00000,8'h00,7'd0,1'b1}, // 16
        {1'b0,2'd0,8'h00,5'b00010,8'h18,7'd0,1'b0}, // 17 R7 billing
        {1'b1,2'd2,8'h00,5'b00000,8'h18,7'd0,1'b0}, // 18 R7 stat write no effect
        {1'b1,2'd0,8'h05,5'b00000,8'h00,7'd0,1'b1}, // 19 R7 enable off clears
        {1'b0,2'd0,8'h00,5'b00010,8'h00,7'd0,1'b1}, // 20 R7 disabled
        {1'b0,2'd0,8'h00,5'b00001,8'h60,7'd0,1'b0}, // 21 R8 dropout
        {1'b1,2'd0,8'h04,5'b00000,8'h60,7'd0,1'b1}, // 22 R6 gie off
        {1'b1,2'd0,8'h06,5'b00000,8'h60,7'd0,1'b0}, // 23 R6 high-active idle
        {1'b1,2'd0,8'h07,5'b00000,8'h60,7'd0,1'b1}, // 24 R6 high-active pending
        {1'b1,2'd2,8'h00,5'b00000,8'h00,7'd0,1'b0}  // 25 R8 cleared
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_pulse(input bit retrig, output int width);
        int w;
        w = 0;
        @(negedge clk);
        ring_cross = 1'b1;
        settle(2);
        ring_cross = 1'b0;
        for (int i = 0; i < 20 && !ring_pin; i++) @(negedge clk);
        while (ring_pin && w < 4 * PULSE) begin
            w++;
            if (retrig && w == 10) ring_cross = 1'b1;
            if (retrig && w == 12) ring_cross = 1'b0;
            @(negedge clk);
        end
        width = w;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int w;
        settle(3);
        // R10 reset state
        reg_read(2'd0, d); check("R10 ctrl", d, 8'h00);
        reg_read(2'd1, d); check("R10 mask", d, 8'h00);
        reg_read(2'd2, d); check("R10 stat", d, 8'h00);
        check("R10 irq", irq_pin, 1'b1);
        check("R10 ring", ring_pin, 1'b0);
        rst_n = 1'b1;
        settle(2);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            @(negedge clk);
            {ring_env, ring_cross, rx_ovl, btone, loop_drop} = v[20:16];
            settle(4);
            if (v[31]) reg_write(v[30:29], v[28:21]);
            settle(3);
            reg_read(2'd2, d);
            check($sformatf("vec%0d stat R1-R8", i), d, v[15:8]);
            check($sformatf("vec%0d irq R6", i), irq_pin, v[0]);
        end

        // R5 live overload mirror
        reg_write(2'd2, 8'h00);
        rx_ovl = 1'b1; settle(5);
        reg_read(2'd3, d); check("R5 live on", d[1], 1'b1);
        rx_ovl = 1'b0; settle(5);
        reg_read(2'd3, d); check("R5 live off", d[1], 1'b0);
        reg_read(2'd2, d); check("R5 sticky kept", d[2:1], 2'b11);

        // R9 ring pin follows envelope
        reg_write(2'd0, 8'h00);
        ring_env = 1'b1; settle(4);
        check("R9 env pin high", ring_pin, 1'b1);
        ring_env = 1'b0; settle(4);
        check("R9 env pin low", ring_pin, 1'b0);

        // R9 one-shot width and no retrigger
        reg_write(2'd0, 8'h08);
        measure_pulse(1'b0, w);
        check("R9 pulse width", w, PULSE);
        settle(5);
        measure_pulse(1'b1, w);
        check("R9 no extend", w, PULSE);
        settle(5);
        check("R9 pulse ended", ring_pin, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule